// File: doc/BRIEF.md
# Encoder Distance Tracker with Slot Pool

This block measures travel distance after fault events on a conveyor-style system. Each time the fault strobe rises, the block claims one counter slot from a pool of ten. The slot copies the current distance setting and then counts rising edges of a raw encoder signal. When the slot has seen enough edges, the block emits a single-clock gate-enable pulse and returns the slot to the pool. Several measurements can run at the same time, so fault events that arrive close together are each tracked to their own completion.

Slots are handed out in strict rotation. If the slot next in line is still running when a new fault edge arrives, the event is dropped and a sticky overflow flag is raised. Both the fault strobe and the encoder signal are asynchronous to the system clock, so each passes through a two-flop synchroniser before edge detection. The asynchronous active-low reset is released synchronously inside the block.

Top module: `enc_dist_tracker`

## Requirements
- R1: While reset is held and after its release, gate_o and ovf_o are 0, every slot is free and the next slot to start is slot 0, so ten fault edges after reset start without overflow.
- R2: Only a 0-to-1 transition of err_i starts a measurement; holding err_i high for many clocks starts exactly one.
- R3: A slot started with distance D makes gate_o high on the (D+1)th rising edge of enc_i after its start; gate_o is high for exactly one clock, in the third clock after enc_i rises (two synchroniser flops and one output register). A fault edge is acted on with the same three-clock latency.
- R4: A distance of 0 completes on the first encoder rising edge after the start, never at the start itself.
- R5: dist_i is captured when the slot starts; later changes of dist_i do not alter a running measurement.
- R6: The next slot index advances by one after each successful start, wrapping from the last slot (9 by default) to 0.
- R7: When a fault edge finds the indexed slot busy, no slot starts, the index does not advance, and ovf_o goes to 1 and stays 1 until reset.
- R8: When several slots complete on the same encoder edge, gate_o pulses once for a single clock.
- R9: When the indexed slot completes on the same clock that a fault edge selects it, gate_o still pulses, the slot restarts with the new distance and no overflow is raised.
- R10: Running slots count the same encoder edges independently, each against its own captured distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_i | input | 1 | Fault strobe, asynchronous; rising edge starts a measurement |
| enc_i | input | 1 | Raw encoder signal, asynchronous; rising edges are counted |
| dist_i | input | DIST_W (32) | Distance setting in encoder edges, captured at start |
| gate_o | output | 1 | One-clock pulse when any measurement completes |
| ovf_o | output | 1 | Sticky flag: a fault edge found its slot still busy |

## Verification
The hardest situation to reach is a fault edge landing on the exact clock where the slot at the rotation index finishes, because it needs a full pool, a known index and a known remaining count all at once. The stimulus fills all ten slots after reset with slot 0 at distance 0 and slot 1 at a short distance, then raises err_i and enc_i on the same clock so both synchronised edges reach the slots together. Further short measurements then prove that the index held on overflow, since a restart on the held slot must produce a pulse that a moved index could not.

// File: rtl/enc_trk_pkg.sv
package enc_trk_pkg;

  localparam int DEF_SLOTS  = 10;
  localparam int DEF_DIST_W = 32;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    SLOT_HOLD   = 2'd0,
    SLOT_LOAD   = 2'd1,
    SLOT_STEP   = 2'd2,
    SLOT_FINISH = 2'd3
  } slot_op_e;

endpackage

// File: rtl/trk_rst_sync.sv
module trk_rst_sync #(
  parameter int STAGES = enc_trk_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/trk_edge_sync.sv
module trk_edge_sync #(
  parameter int STAGES = enc_trk_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/trk_slot.sv
module trk_slot
  import enc_trk_pkg::*;
#(
  parameter int DIST_W = DEF_DIST_W
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [DIST_W-1:0] load_i,
  output logic              busy_o,
  output logic              done_o
);

  logic              busy_q, busy_d;
  logic [DIST_W-1:0] cnt_q, cnt_d;
  logic [DIST_W-1:0] tgt_q, tgt_d;
  logic              hit;
  logic              clk_en;
  slot_op_e          op;

  assign hit = busy_q & step_i & (cnt_q == tgt_q);

  always_comb begin
    if (start_i) begin
      op = SLOT_LOAD;
    end else if (hit) begin
      op = SLOT_FINISH;
    end else if (busy_q & step_i) begin
      op = SLOT_STEP;
    end else begin
      op = SLOT_HOLD;
    end
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    tgt_d  = tgt_q;
    unique case (op)
      SLOT_LOAD: begin
        busy_d = 1'b1;
        cnt_d  = '0;
        tgt_d  = load_i;
      end
      SLOT_FINISH: begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end
      SLOT_STEP: begin
        cnt_d = cnt_q + DIST_W'(1);
      end
      default: begin
      end
    endcase
  end

  assign clk_en = (op != SLOT_HOLD);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tgt_q  <= '0;
    end else if (clk_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      tgt_q  <= tgt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = hit;

endmodule

// File: rtl/trk_alloc.sv
module trk_alloc
  import enc_trk_pkg::*;
#(
  parameter int NUM_SLOTS = DEF_SLOTS,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic                 req_i,
  input  logic [NUM_SLOTS-1:0] busy_i,
  input  logic [NUM_SLOTS-1:0] done_i,
  output logic [NUM_SLOTS-1:0] start_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 ovf_o
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             ovf_q, ovf_d;
  logic             sel_free;
  logic             clk_en;

  always_comb begin
    sel_free = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (idx_q == IDX_W'(i)) begin
        sel_free = ~busy_i[i] | done_i[i];
      end
    end
  end

  always_comb begin
    start_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      start_o[i] = req_i & sel_free & (idx_q == IDX_W'(i));
    end
  end

  always_comb begin
    idx_d = idx_q;
    ovf_d = ovf_q;
    if (req_i) begin
      if (sel_free) begin
        idx_d = (idx_q == IDX_W'(NUM_SLOTS - 1)) ? '0 : idx_q + IDX_W'(1);
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  assign clk_en = req_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      idx_q <= '0;
      ovf_q <= 1'b0;
    end else if (clk_en) begin
      idx_q <= idx_d;
      ovf_q <= ovf_d;
    end
  end

  assign idx_o = idx_q;
  assign ovf_o = ovf_q;

endmodule

// File: rtl/enc_dist_tracker.sv
module enc_dist_tracker
  import enc_trk_pkg::*;
#(
  parameter int NUM_SLOTS = DEF_SLOTS,
  parameter int DIST_W    = DEF_DIST_W,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              err_i,
  input  logic              enc_i,
  input  logic [DIST_W-1:0] dist_i,
  output logic              gate_o,
  output logic              ovf_o
);

  logic                 rst_sync_n;
  logic                 err_rise;
  logic                 enc_rise;
  logic [NUM_SLOTS-1:0] busy_vec;
  logic [NUM_SLOTS-1:0] done_vec;
  logic [NUM_SLOTS-1:0] start_vec;
  logic [IDX_W-1:0]     alloc_idx;
  logic                 gate_q;

  trk_rst_sync u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_sync_n)
  );

  trk_edge_sync u_err_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .async_i (err_i),
    .rise_o  (err_rise)
  );

  trk_edge_sync u_enc_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .async_i (enc_i),
    .rise_o  (enc_rise)
  );

  trk_alloc #(
    .NUM_SLOTS (NUM_SLOTS)
  ) u_alloc (
    .clk_i   (clk_i),
    .rst_n_i (rst_sync_n),
    .req_i   (err_rise),
    .busy_i  (busy_vec),
    .done_i  (done_vec),
    .start_o (start_vec),
    .idx_o   (alloc_idx),
    .ovf_o   (ovf_o)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    trk_slot #(
      .DIST_W (DIST_W)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_n_i (rst_sync_n),
      .start_i (start_vec[g]),
      .step_i  (enc_rise),
      .load_i  (dist_i),
      .busy_o  (busy_vec[g]),
      .done_o  (done_vec[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= |done_vec;
    end
  end

  assign gate_o = gate_q;

endmodule

// File: rtl/enc_dist_tracker_chk.sv
module enc_dist_tracker_chk #(
  parameter int NUM_SLOTS = 10,
  parameter int IDX_W     = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] busy,
  input logic [NUM_SLOTS-1:0] start,
  input logic [IDX_W-1:0]     idx,
  input logic                 gate,
  input logic                 ovf
);

  // R8: a completion never stretches past one clock
  assert_gate_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> !gate);

  // R7: overflow is sticky
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R7: the index holds when overflow is raised
  assert_ovf_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(idx));

  // R6: index stays inside the pool
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx < IDX_W'(NUM_SLOTS));

  // R6: at most one slot starts per clock
  assert_one_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));

  // R9: a started slot is busy on the next clock
  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start != '0) |=> ((busy & $past(start)) == $past(start)));

  // R3: a pulse needs a slot that was running
  assert_gate_from_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> ($past(busy) != '0));

endmodule

bind enc_dist_tracker enc_dist_tracker_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .IDX_W     (IDX_W)
) i_chk (
  .clk   (clk_i),
  .rst_n (rst_sync_n),
  .busy  (busy_vec),
  .start (start_vec),
  .idx   (alloc_idx),
  .gate  (gate_o),
  .ovf   (ovf_o)
);

// File: tb/test_enc_dist_tracker.sv
`timescale 1ns/1ps
module test_enc_dist_tracker;

  localparam int SLOTS = 10;
  localparam int DW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          err_i;
  logic          enc_i;
  logic [DW-1:0] dist_i;
  logic          gate_o;
  logic          ovf_o;

  always #2.5 clk = ~clk;

  enc_dist_tracker i_enc_dist_tracker (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .err_i   (err_i),
    .enc_i   (enc_i),
    .dist_i  (dist_i),
    .gate_o  (gate_o),
    .ovf_o   (ovf_o)
  );

  int    total = 0;
  int    bad   = 0;
  int    now   = 0;
  bit    finished = 0;
  int    exp_q[$];
  string tag_q[$];

  bit    mbusy[SLOTS];
  int    mrem[SLOTS];
  int    midx;
  bit    movf;

  always @(posedge clk) now++;

  // monitor: pops expected pulses and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (gate_o) begin
        total++;
        if (exp_q.size() > 0 && exp_q[0] == now) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end else begin
          bad++;
          $display("FAIL R3 unexpected gate pulse at %0d: actual=1 expected=0", now);
        end
      end else if (exp_q.size() > 0 && exp_q[0] <= now) begin
        total++;
        bad++;
        $display("FAIL %s missing gate pulse at %0d: actual=0 expected=1", tag_q[0], exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  function automatic void model_enc(string tag);
    bit any = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (mbusy[i]) begin
        mrem[i]--;
        if (mrem[i] == 0) begin
          mbusy[i] = 0;
          any = 1;
        end
      end
    end
    if (any) begin
      exp_q.push_back(now + 3);
      tag_q.push_back(tag);
    end
  endfunction

  function automatic void model_err(int d);
    if (!mbusy[midx]) begin
      mbusy[midx] = 1;
      mrem[midx]  = d + 1;
      midx = (midx + 1) % SLOTS;
    end else begin
      movf = 1;
    end
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_enc(string tag);
    @(negedge clk);
    enc_i = 1'b1;
    model_enc(tag);
    @(negedge clk);
    enc_i = 1'b0;
    settle();
  endtask

  task automatic t_err(int d, int hold);
    @(negedge clk);
    dist_i = DW'(d);
    err_i  = 1'b1;
    model_err(d);
    repeat (hold) @(negedge clk);
    err_i = 1'b0;
    settle();
  endtask

  task automatic t_both(int d, string tag);
    @(negedge clk);
    dist_i = DW'(d);
    err_i  = 1'b1;
    enc_i  = 1'b1;
    model_enc(tag);
    model_err(d);
    @(negedge clk);
    err_i = 1'b0;
    enc_i = 1'b0;
    settle();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < SLOTS; i++) begin
      mbusy[i] = 0;
      mrem[i]  = 0;
    end
    midx = 0;
    movf = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk(logic act, logic exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    err_i  = 1'b0;
    enc_i  = 1'b0;
    dist_i = '0;
    repeat (3) @(negedge clk);
    chk(gate_o, 1'b0, "R1 gate in reset");
    chk(ovf_o, 1'b0, "R1 ovf in reset");
    do_reset();
    chk(gate_o, 1'b0, "R1 gate after reset");
    chk(ovf_o, 1'b0, "R1 ovf after reset");

    // R3 / R5: distance 3, input changed after start
    t_err(3, 1);
    dist_i = DW'(100);
    for (int k = 0; k < 4; k++) t_enc("R3_R5");

    // R4: distance zero
    t_err(0, 1);
    t_enc("R4");
    t_enc("R4");

    // R8: two slots finishing on one edge
    t_err(1, 1);
    t_enc("R8");
    t_err(0, 1);
    t_enc("R8");
    t_enc("R8");

    // R10: overlapping independent counts
    t_err(2, 1);
    t_enc("R10");
    t_err(0, 1);
    t_enc("R10");
    t_enc("R10");
    chk(ovf_o, 1'b0, "R10 no overflow");

    // R2 / R7: level held starts one slot; pool fills; overflow
    do_reset();
    t_err(1000, 8);
    for (int k = 0; k < 9; k++) t_err(1000, 1);
    chk(ovf_o, 1'b0, "R2 level started only one slot");
    t_err(1000, 1);
    chk(ovf_o, 1'b1, "R7 overflow on busy slot");
    t_enc("R7");
    t_enc("R7");
    chk(ovf_o, 1'b1, "R7 overflow sticky");

    // R1 / R6: reset clears pool and index; ten starts wrap cleanly
    do_reset();
    chk(ovf_o, 1'b0, "R1 overflow cleared by reset");
    chk(gate_o, 1'b0, "R1 gate cleared by reset");
    for (int k = 0; k < 10; k++) t_err(1000, 1);
    chk(ovf_o, 1'b0, "R6 ten starts without overflow");

    // R9 / R7 / R6: free-and-restart on one edge, index hold
    do_reset();
    t_err(0, 1);
    t_err(3, 1);
    for (int k = 0; k < 8; k++) t_err(1000, 1);
    t_both(5, "R9");
    chk(ovf_o, 1'b0, "R9 restart on completing slot");
    t_err(0, 1);
    chk(ovf_o, 1'b1, "R7 overflow with slot 1 busy");
    for (int k = 0; k < 3; k++) t_enc("R7");
    t_err(0, 1);
    t_enc("R7 index held");
    t_enc("R9");
    t_enc("R9");
    chk(ovf_o, 1'b1, "R7 overflow still set");

    repeat (6) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R3 pending pulses: actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule